// File: doc/BRIEF.md
# Reloadable Down-Counting Interrupt Timer

This block is a memory-mapped countdown timer for a peripheral subsystem. Software writes a start value, selects one of two tick sources and a counting mode, and enables it. On each pulse of the selected tick input the counter steps down by one. When a tick arrives while the counter already holds zero, an underflow occurs. In periodic mode the counter then restarts from the stored start value. In free-running mode it wraps to all ones. Every underflow raises a sticky interrupt line that stays high until software writes to the acknowledge register.

The counter width is a parameter; 16 and 32 bits are the intended settings, and the logic is the same for both. The tick inputs are single-cycle enables produced elsewhere from the system clock, nominally about 508 kHz (fast) and 2 kHz (slow). A run/halt state machine has two states, HALT and COUNT. The transition HALT to COUNT (named START) is taken on a control write with the enable bit set. The transition COUNT to HALT (named STOP) is taken on a control write with the enable bit clear. Every other cycle stays in the current state.

Top module: `rld_timer`

## Requirements
- R1: After reset the start-value, counter and control registers read 0 and the interrupt output is low.
- R2: Word registers sit at byte addresses 0x0 (start value, read/write), 0x4 (counter, read-only; writes ignored), 0x8 (control) and 0xC (acknowledge, write-only, reads 0).
- R3: Control bit 7 is enable, bit 6 selects periodic mode when 1, bit 3 selects the fast tick when 1 (slow tick when 0); every other control bit reads 0.
- R4: A write to the start-value register also loads the counter in the same clock edge, and it takes priority over a tick in that cycle.
- R5: While enabled, the counter decreases by exactly one per pulse of the selected tick; pulses on the unselected tick have no effect.
- R6: In periodic mode, a tick at count 0 reloads the start value, so the counter returns to its start value every start+1 ticks.
- R7: In free-running mode, a tick at count 0 wraps the counter to all ones (0xFFFF at 16 bits).
- R8: Every underflow drives the interrupt high from the next cycle, and it stays high until acknowledged.
- R9: A write of any data to the acknowledge register clears the interrupt; an underflow in the same cycle wins, and the interrupt stays high.
- R10: While disabled (a write of 0 to control stops it), the counter holds its value and a pending interrupt stays pending.
- R11: Bits of the start value above the counter width are dropped on write, and they read as zero in the start-value and counter registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits 1:0 must be zero for a hit |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| tick_fast | input | 1 | Fast time-base enable pulse |
| tick_slow | input | 1 | Slow time-base enable pulse |
| irq | output | 1 | Sticky underflow interrupt |

## Verification
The bound checker checks on every cycle the per-tick decrement, how the counter holds while halted or between ticks, the periodic reload and free-running wrap values, the immediate load, the interrupt set, hold and clear rules, and the zero bits of the control register. Only the bench scenarios can show whole sequences. These include the exact period for a sweep of start values in both modes, the read-back address map, the truncation of wide start values and the priority of simultaneous events seen at the ports.

// File: rtl/rld_timer_pkg.sv
package rld_timer_pkg;

    typedef enum logic [0:0] {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_t;

    // Word index (byte address bits 3:2)
    localparam logic [1:0] WI_START = 2'd0;
    localparam logic [1:0] WI_COUNT = 2'd1;
    localparam logic [1:0] WI_CTRL  = 2'd2;
    localparam logic [1:0] WI_ACK   = 2'd3;

    // Control bit positions
    localparam int CB_ENABLE   = 7;
    localparam int CB_PERIODIC = 6;
    localparam int CB_FASTSEL  = 3;

endpackage

// File: rtl/rld_timer_regs.sv
module rld_timer_regs
    import rld_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              running,
    output logic [CNT_W-1:0]  start_q,
    output logic              periodic_q,
    output logic              fast_sel_q,
    output logic              wr_start,
    output logic              wr_ctrl,
    output logic              wr_ack,
    output logic [DATA_W-1:0] bus_rdata
);

    logic       aligned;
    logic [1:0] widx;
    logic       wr_hit;
    logic       unused_wdata_bits;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign widx    = bus_addr[3:2];
    assign wr_hit  = bus_sel && bus_wr && aligned;

    assign wr_start = wr_hit && (widx == WI_START);
    assign wr_ctrl  = wr_hit && (widx == WI_CTRL);
    assign wr_ack   = wr_hit && (widx == WI_ACK);

    assign unused_wdata_bits = ^bus_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q    <= '0;
            periodic_q <= 1'b0;
            fast_sel_q <= 1'b0;
        end else begin
            if (wr_start) begin
                start_q <= bus_wdata[CNT_W-1:0];
            end
            if (wr_ctrl) begin
                periodic_q <= bus_wdata[CB_PERIODIC];
                fast_sel_q <= bus_wdata[CB_FASTSEL];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && aligned) begin
            unique case (widx)
                WI_START: bus_rdata = DATA_W'(start_q);
                WI_COUNT: bus_rdata = DATA_W'(count);
                WI_CTRL: begin
                    bus_rdata[CB_ENABLE]   = running;
                    bus_rdata[CB_PERIODIC] = periodic_q;
                    bus_rdata[CB_FASTSEL]  = fast_sel_q;
                end
                WI_ACK:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/rld_timer_core.sv
module rld_timer_core
    import rld_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_fast,
    input  logic             tick_slow,
    input  logic             fast_sel,
    input  logic             periodic,
    input  logic             wr_ctrl,
    input  logic             ctrl_enable,
    input  logic             wr_start,
    input  logic [CNT_W-1:0] start_new,
    input  logic [CNT_W-1:0] start_q,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             underflow
);

    run_state_t state, state_nxt;
    logic       tick_sel;
    logic       step;
    logic       at_zero;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HALT;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions: START and STOP
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HALT:  if (wr_ctrl && ctrl_enable)  state_nxt = ST_COUNT;
            ST_COUNT: if (wr_ctrl && !ctrl_enable) state_nxt = ST_HALT;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        running   = (state == ST_COUNT);
        tick_sel  = fast_sel ? tick_fast : tick_slow;
        at_zero   = (count == '0);
        step      = running && tick_sel && !wr_start;
        underflow = step && at_zero;
    end

    // Counter datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_start) begin
            count <= start_new;
        end else if (step) begin
            if (at_zero) begin
                count <= periodic ? start_q : '1;
            end else begin
                count <= count - 1'b1;
            end
        end
    end

endmodule

// File: rtl/rld_timer_irq.sv
module rld_timer_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic underflow,
    input  logic wr_ack,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (underflow) begin
            irq <= 1'b1;
        end else if (wr_ack) begin
            irq <= 1'b0;
        end
    end

endmodule

// File: rtl/rld_timer.sv
module rld_timer
    import rld_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_fast,
    input  logic              tick_slow,
    output logic              irq
);

    logic [CNT_W-1:0] cnt_value;
    logic [CNT_W-1:0] start_val_q;
    logic             run_q;
    logic             periodic_q;
    logic             fast_sel_q;
    logic             wr_start;
    logic             wr_ctrl;
    logic             wr_ack;
    logic             uflow;

    rld_timer_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .count      (cnt_value),
        .running    (run_q),
        .start_q    (start_val_q),
        .periodic_q (periodic_q),
        .fast_sel_q (fast_sel_q),
        .wr_start   (wr_start),
        .wr_ctrl    (wr_ctrl),
        .wr_ack     (wr_ack),
        .bus_rdata  (bus_rdata)
    );

    rld_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_fast   (tick_fast),
        .tick_slow   (tick_slow),
        .fast_sel    (fast_sel_q),
        .periodic    (periodic_q),
        .wr_ctrl     (wr_ctrl),
        .ctrl_enable (bus_wdata[CB_ENABLE]),
        .wr_start    (wr_start),
        .start_new   (bus_wdata[CNT_W-1:0]),
        .start_q     (start_val_q),
        .count       (cnt_value),
        .running     (run_q),
        .underflow   (uflow)
    );

    rld_timer_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .underflow (uflow),
        .wr_ack    (wr_ack),
        .irq       (irq)
    );

endmodule

// File: rtl/rld_timer_chk.sv
module rld_timer_chk #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [3:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tick_fast,
    input logic              tick_slow,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt_value,
    input logic [CNT_W-1:0]  start_val_q,
    input logic              run_q,
    input logic              periodic_q,
    input logic              fast_sel_q,
    input logic              wr_start,
    input logic              wr_ack,
    input logic              uflow
);

    logic sel_tick;
    assign sel_tick = fast_sel_q ? tick_fast : tick_slow;

    a_r8_uflow_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> irq);

    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_ack) |=> irq);

    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && !uflow) |=> !irq);

    a_r10_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr_start) |=> $stable(cnt_value));

    a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && sel_tick && (cnt_value != '0) && !wr_start)
        |=> (cnt_value == CNT_W'($past(cnt_value) - 1'b1)));

    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !sel_tick && !wr_start) |=> $stable(cnt_value));

    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow && periodic_q) |=> (cnt_value == $past(start_val_q)));

    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow && !periodic_q) |=> (&cnt_value));

    a_r4_load_now: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> (cnt_value == $past(bus_wdata[CNT_W-1:0])));

    a_r3_ctrl_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_addr == 4'h8))
        |-> ((bus_rdata & ~DATA_W'(32'hC8)) == '0));

endmodule

bind rld_timer rld_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .tick_fast   (tick_fast),
    .tick_slow   (tick_slow),
    .irq         (irq),
    .cnt_value   (cnt_value),
    .start_val_q (start_val_q),
    .run_q       (run_q),
    .periodic_q  (periodic_q),
    .fast_sel_q  (fast_sel_q),
    .wr_start    (wr_start),
    .wr_ack      (wr_ack),
    .uflow       (uflow)
);

// File: tb/rld_timer_bench.sv
`timescale 1ns/1ps
module rld_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        tick_fast = 1'b0;
    logic        tick_slow = 1'b0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    rld_timer #(.CNT_W(16), .DATA_W(32)) u_rld_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input logic fast);
        @(negedge clk);
        if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
        @(negedge clk);
        tick_fast = 1'b0; tick_slow = 1'b0;
    endtask

    // Bus write and a fast tick landing on the same clock edge
    task automatic write_with_tick(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_fast = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tick_fast = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(4'h0, rd); check("R1 start reg", rd, 32'h0);
        bus_read(4'h4, rd); check("R1 counter", rd, 32'h0);
        bus_read(4'h8, rd); check("R1 control", rd, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);

        // R3 only three control bits exist
        bus_write(4'h8, 32'hFFFF_FFFF);
        bus_read(4'h8, rd); check("R3 control bits", rd, 32'h0000_00C8);
        bus_write(4'h8, 32'h0);
        bus_read(4'h8, rd); check("R3 control cleared", rd, 32'h0);

        // R11 / R4 wide start value truncated, counter loaded at once
        bus_write(4'h0, 32'h0001_2345);
        bus_read(4'h0, rd); check("R11 start truncated", rd, 32'h0000_2345);
        bus_read(4'h4, rd); check("R4 counter loaded", rd, 32'h0000_2345);

        // R2 counter write ignored, ack reads zero
        bus_write(4'h4, 32'h0000_1111);
        bus_read(4'h4, rd); check("R2 counter read-only", rd, 32'h0000_2345);
        bus_read(4'hC, rd); check("R2 ack reads zero", rd, 32'h0);

        // R6 / R8 periodic sweep over start values
        for (int L = 0; L < 8; L++) begin
            bus_write(4'h8, 32'h0);
            bus_write(4'hC, 32'h0);
            bus_write(4'h0, L);
            bus_write(4'h8, 32'hC8);
            for (int k = 1; k <= 2 * L + 3; k++) begin
                pulse(1'b1);
                check("R8 irq periodic", {31'h0, irq}, (k >= L + 1) ? 32'h1 : 32'h0);
                bus_read(4'h4, rd);
                check("R6 periodic value", rd, L - (k % (L + 1)));
            end
        end

        // R7 free-running sweep
        for (int L = 0; L < 4; L++) begin
            bus_write(4'h8, 32'h0);
            bus_write(4'hC, 32'h5A5A);
            bus_write(4'h0, L);
            bus_write(4'h8, 32'h88);
            for (int k = 1; k <= L + 3; k++) begin
                pulse(1'b1);
                bus_read(4'h4, rd);
                check("R7 free value", rd, (k <= L) ? (L - k) : (32'hFFFF - (k - L - 1)));
                check("R8 irq free", {31'h0, irq}, (k > L) ? 32'h1 : 32'h0);
            end
        end

        // R5 tick selection
        bus_write(4'h8, 32'h0);
        bus_write(4'hC, 32'h0);
        bus_write(4'h0, 32'd5);
        bus_write(4'h8, 32'hC0);
        repeat (3) pulse(1'b1);
        bus_read(4'h4, rd); check("R5 fast ignored when slow selected", rd, 32'd5);
        repeat (2) pulse(1'b0);
        bus_read(4'h4, rd); check("R5 slow ticks counted", rd, 32'd3);

        // R10 halt holds counter and pending irq
        bus_write(4'h8, 32'h0);
        bus_write(4'h0, 32'd1);
        bus_write(4'h8, 32'hC8);
        repeat (2) pulse(1'b1);
        check("R8 irq after underflow", {31'h0, irq}, 32'h1);
        bus_write(4'h8, 32'h0);
        repeat (3) pulse(1'b1);
        bus_read(4'h4, rd); check("R10 counter held", rd, 32'd1);
        check("R10 irq held", {31'h0, irq}, 32'h1);
        bus_read(4'h8, rd); check("R10 control reads stopped", rd, 32'h0);

        // R9 any value acknowledges
        bus_write(4'hC, 32'h0000_DEAD);
        check("R9 irq cleared", {31'h0, irq}, 32'h0);

        // R9 underflow wins over a simultaneous acknowledge
        bus_write(4'h0, 32'd0);
        bus_write(4'h8, 32'hC8);
        write_with_tick(4'hC, 32'h1);
        check("R9 underflow beats ack", {31'h0, irq}, 32'h1);
        bus_write(4'hC, 32'h0);
        check("R9 irq cleared again", {31'h0, irq}, 32'h0);

        // R4 start write beats a tick in the same cycle
        write_with_tick(4'h0, 32'h0000_0042);
        bus_read(4'h4, rd); check("R4 load beats tick", rd, 32'h42);
        check("R4 no underflow on load", {31'h0, irq}, 32'h0);
        pulse(1'b1);
        bus_read(4'h4, rd); check("R5 step after load", rd, 32'h41);

        summary();
        $finish;
    end

endmodule